// File: doc/BRIEF.md
# Rotate-Based Round Robin Arbiter

This block shares one bus among four requestors. In every cycle it reads a 4-bit request vector and drives a 4-bit grant vector. The grant is all zeros when nothing is requested. Otherwise it is one-hot. A registered priority pointer names the requestor that currently ranks first.

The grant path is purely combinational. The request vector is rotated so that the pointed requestor lands in local slot 0. A plain fixed-priority picker then takes the lowest set slot. The resulting one-hot vector is rotated back by the same amount, which restores the original requestor numbering. On each rising clock edge that carries a grant, the pointer moves to the requestor just after the winner. The winner therefore drops to the bottom of the order, and service cycles through all requestors.

Top module: `rr_rotate_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the pointer to requestor 0. With all four requests high right after reset, the grant is 4'b0001.
- R2: When the request vector is 4'b0000, the grant is 4'b0000.
- R3: When any request is high, the grant has exactly one bit set, and that bit is set in the request vector.
- R4: If the requestor named by the pointer is requesting, it receives the grant.
- R5: Otherwise the grant goes to the first requesting index found when counting upward from the pointer and wrapping from 3 to 0.
- R6: On a clock edge with a nonzero grant, the pointer becomes the granted index plus one, modulo 4.
- R7: On a clock edge with no request, the pointer keeps its value.
- R8: A requestor that holds its request high receives the grant within at most 4 consecutive cycles.
- R9: The grant follows a change of the request vector in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the pointer register |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request vector; bit i is requestor i |
| gnt | output | 4 | Grant vector; one-hot or zero, bit i grants requestor i |

## Verification
The grant depends combinationally on the request and on the registered pointer. It is therefore due in the same cycle as the request change. The bench drives each request vector on the falling edge and samples the grant 1 time unit later, with no rising edge in between. The effect of a grant on the pointer shows up only in the grant of the next cycle. The bench reads that effect after exactly one rising edge, using vectors that include all requestors. The same-cycle requirement is checked by changing the request twice within one low clock phase.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;

    parameter int unsigned REQ_N = 4;
    localparam int unsigned PTR_W = (REQ_N > 1) ? $clog2(REQ_N) : 1;

    typedef logic [REQ_N-1:0] req_vec_t;
    typedef logic [PTR_W-1:0] ptr_t;

    // Result of the fixed-priority stage in local (rotated) numbering
    typedef struct packed {
        logic     hit;
        ptr_t     slot;
        req_vec_t onehot;
    } pick_t;

    // Direction of a rotation stage
    typedef enum logic {
        ROT_TO_LOCAL  = 1'b0,
        ROT_TO_GLOBAL = 1'b1
    } rot_dir_e;

    // (a + b) mod REQ_N
    function automatic ptr_t slot_add(ptr_t a, ptr_t b);
        int s;
        s = int'(a) + int'(b);
        if (s >= int'(REQ_N)) s = s - int'(REQ_N);
        return ptr_t'(s);
    endfunction

    // (a - b) mod REQ_N
    function automatic ptr_t slot_sub(ptr_t a, ptr_t b);
        int s;
        s = int'(a) - int'(b);
        if (s < 0) s = s + int'(REQ_N);
        return ptr_t'(s);
    endfunction

endpackage

// File: rtl/rr_rotate.sv
module rr_rotate
    import rrarb_pkg::*;
#(
    parameter rot_dir_e DIR = ROT_TO_LOCAL
) (
    input  req_vec_t vec_i,
    input  ptr_t     amt_i,
    output req_vec_t vec_o
);

    // To local: slot i holds global index (i + amt).
    // To global: index j takes local slot (j - amt).
    generate
        if (DIR == ROT_TO_LOCAL) begin : g_to_local
            for (genvar i = 0; i < int'(REQ_N); i++) begin : g_bit
                assign vec_o[i] = vec_i[slot_add(ptr_t'(i), amt_i)];
            end
        end else begin : g_to_global
            for (genvar j = 0; j < int'(REQ_N); j++) begin : g_bit
                assign vec_o[j] = vec_i[slot_sub(ptr_t'(j), amt_i)];
            end
        end
    endgenerate

endmodule

// File: rtl/rr_fixed_pick.sv
module rr_fixed_pick
    import rrarb_pkg::*;
(
    input  req_vec_t vec_i,
    output pick_t    pick_o
);

    // Lowest set slot wins; scanning downward lets the lowest overwrite
    always_comb begin
        pick_o = '0;
        for (int i = int'(REQ_N) - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                pick_o.hit       = 1'b1;
                pick_o.slot      = ptr_t'(i);
                pick_o.onehot    = '0;
                pick_o.onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rr_ptr_reg.sv
module rr_ptr_reg
    import rrarb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  ptr_t win_i,
    output ptr_t ptr_o
);

    ptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (adv_i) begin
            ptr_q <= slot_add(win_i, ptr_t'(1));
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/rr_rotate_arbiter.sv
module rr_rotate_arbiter
    import rrarb_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [rrarb_pkg::REQ_N-1:0]  req,
    output logic [rrarb_pkg::REQ_N-1:0]  gnt
);

    ptr_t     ptr_q;
    req_vec_t req_local;
    pick_t    pick;
    req_vec_t gnt_global;
    ptr_t     win_slot;

    rr_rotate #(.DIR(ROT_TO_LOCAL)) u_rot_in (
        .vec_i (req),
        .amt_i (ptr_q),
        .vec_o (req_local)
    );

    rr_fixed_pick u_pick (
        .vec_i  (req_local),
        .pick_o (pick)
    );

    rr_rotate #(.DIR(ROT_TO_GLOBAL)) u_rot_out (
        .vec_i (pick.onehot),
        .amt_i (ptr_q),
        .vec_o (gnt_global)
    );

    // Winner in global numbering
    assign win_slot = slot_add(pick.slot, ptr_q);

    rr_ptr_reg u_ptr (
        .clk   (clk),
        .rst   (rst),
        .adv_i (pick.hit),
        .win_i (win_slot),
        .ptr_o (ptr_q)
    );

    assign gnt = gnt_global;

endmodule

// File: rtl/rr_rotate_arbiter_chk.sv
module rr_rotate_arbiter_chk
    import rrarb_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input req_vec_t req,
    input req_vec_t gnt,
    input ptr_t     ptr
);

    function automatic ptr_t onehot_slot(req_vec_t v);
        ptr_t s;
        s = '0;
        for (int i = 0; i < int'(REQ_N); i++) begin
            if (v[i]) s = ptr_t'(i);
        end
        return s;
    endfunction

    // Expected grant by cyclic search from the pointer
    function automatic req_vec_t cyclic_first(req_vec_t r, ptr_t p);
        req_vec_t g;
        g = '0;
        for (int k = int'(REQ_N) - 1; k >= 0; k--) begin
            if (r[slot_add(p, ptr_t'(k))]) begin
                g = '0;
                g[slot_add(p, ptr_t'(k))] = 1'b1;
            end
        end
        return g;
    endfunction

    ptr_t nxt_q;
    always_ff @(posedge clk) begin
        nxt_q <= slot_add(onehot_slot(gnt), ptr_t'(1));
    end

    a_r1_reset_ptr: assert property (@(posedge clk)
        rst |=> ptr == '0);

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        req == '0 |-> gnt == '0);

    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        req != '0 |-> $countones(gnt) == 1);

    a_r3_subset: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    a_r4_pointed_wins: assert property (@(posedge clk) disable iff (rst)
        req[ptr] |-> gnt[ptr]);

    a_r5_cyclic_first: assert property (@(posedge clk) disable iff (rst)
        gnt == cyclic_first(req, ptr));

    a_r6_advance: assert property (@(posedge clk) disable iff (rst)
        gnt != '0 |=> ptr == nxt_q);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        req == '0 |=> $stable(ptr));

endmodule

bind rr_rotate_arbiter rr_rotate_arbiter_chk u_chk (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt),
    .ptr (ptr_q)
);

// File: tb/rr_rotate_arbiter_test.sv
module rr_rotate_arbiter_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = 4'b0000;
    logic [3:0] gnt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    rr_rotate_arbiter uut (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (gnt)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 unit later (no rising edge between)
    task automatic apply(logic [3:0] r);
        @(negedge clk);
        req = r;
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        req = 4'b0000;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Reference: first requesting index counting up from p, wrapping
    function automatic logic [3:0] model_pick(logic [3:0] r, int p);
        for (int k = 0; k < 4; k++) begin
            if (r[(p + k) % 4]) return 4'(1 << ((p + k) % 4));
        end
        return 4'b0000;
    endfunction

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        req = 4'b1111;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R1 grant while in reset", gnt, 4'b0001);
        rst = 1'b0;
        req = 4'b0000;
        apply(4'b1111);
        chk("R1 first grant after reset", gnt, 4'b0001);
    endtask

    task automatic t_rotation;
        do_reset();
        apply(4'b1111); chk("R6 rotation step 0", gnt, 4'b0001);
        apply(4'b1111); chk("R6 rotation step 1", gnt, 4'b0010);
        apply(4'b1111); chk("R6 rotation step 2", gnt, 4'b0100);
        apply(4'b1111); chk("R6 rotation step 3", gnt, 4'b1000);
        apply(4'b1111); chk("R8 rotation wraps to 0", gnt, 4'b0001);
    endtask

    task automatic t_idle;
        do_reset();
        apply(4'b1111); chk("R6 idle prep grant 0", gnt, 4'b0001);
        apply(4'b0010); chk("R3 single request", gnt, 4'b0010);
        for (int i = 0; i < 3; i++) begin
            apply(4'b0000); chk("R2 no request no grant", gnt, 4'b0000);
        end
        apply(4'b1111); chk("R7 pointer held over idle", gnt, 4'b0100);
    endtask

    task automatic t_skip;
        do_reset();
        apply(4'b1010); chk("R5 skip to 1", gnt, 4'b0010);
        apply(4'b1010); chk("R5 skip to 3", gnt, 4'b1000);
        apply(4'b0011); chk("R5 wrap to 0", gnt, 4'b0001);
        apply(4'b0011); chk("R5 next is 1", gnt, 4'b0010);
        apply(4'b0011); chk("R5 wrap from 2 to 0", gnt, 4'b0001);
    endtask

    task automatic t_pointed;
        do_reset();
        apply(4'b0100); chk("R3 lone request 2", gnt, 4'b0100);
        apply(4'b1111); chk("R4 pointed 3 wins", gnt, 4'b1000);
        apply(4'b1001); chk("R4 pointed 0 wins", gnt, 4'b0001);
    endtask

    task automatic t_comb;
        do_reset();
        @(negedge clk);
        req = 4'b0001;
        #1;
        chk("R9 grant 0 same cycle", gnt, 4'b0001);
        #1;
        req = 4'b1000;
        #1;
        chk("R9 grant follows change", gnt, 4'b1000);
        #1;
        req = 4'b1001;
        #1;
        chk("R9 pointer unchanged within cycle", gnt, 4'b0001);
    endtask

    task automatic t_fair;
        logic [7:0] lfsr;
        int mptr;
        int waited;
        logic [3:0] r;
        logic [3:0] exp;
        do_reset();
        lfsr   = 8'hA5;
        mptr   = 0;
        waited = 0;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            r    = lfsr[3:0] | 4'b0100;
            apply(r);
            exp = model_pick(r, mptr);
            chk("R5 mixed pattern", gnt, exp);
            chk("R3 grant within requests", gnt & ~r, 4'b0000);
            if (gnt[2]) begin
                chk("R8 wait bound for requestor 2",
                    (waited <= 3) ? 4'b0001 : 4'b0000, 4'b0001);
                waited = 0;
            end else begin
                waited++;
            end
            for (int k = 0; k < 4; k++) begin
                if (exp[k]) mptr = (k + 1) % 4;
            end
        end
    endtask

    initial begin
        t_reset();
        t_rotation();
        t_idle();
        t_skip();
        t_pointed();
        t_comb();
        t_fair();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule